// File: doc/BRIEF.md
# Port-Access Instruction Bus Sequencer

This block produces the bus activity of a small 8-bit processor for its two port-access instructions: the one that reads a byte from an input port, and the one that writes a byte to an output port. The instruction has already been decoded. The block accepts a request that says which of the two it is and gives the address of the opcode. It then runs three machine cycles and ten T-states, one clock per T-state:

- an opcode fetch;
- a memory read of the following byte, which is the port number;
- an I/O cycle, either a read or a write.

During the I/O cycle, the port number is driven onto both halves of the address. The upper byte alone is therefore enough for a device to decode its select. The IO/M status line is high only during this cycle. Input ports and output ports are separate spaces, with 256 of each, because the direction is given by the strobe that is used.

The block holds the accumulator byte. A read instruction loads this register from the data lines. A write instruction drives it onto them. The rest of the processor can load the accumulator through a write port, but only while the sequencer is idle. A one-clock completion pulse follows the last T-state. A new request is accepted in that same clock, so instructions can run back to back.

Top module: `portio_seq`

## Requirements
- R1: After reset, and whenever idle, the outputs are as follows: rdN and wrN are 1; ale, ioM, adOe, busy and done are 0; addrHi is 0. The accumulator resets to 00H.
- R2: A request sampled while idle starts a 10-clock run: fetch for T1–T4 (clocks 1–4), memory read for T1–T3 (clocks 5–7), I/O cycle for T1–T3 (clocks 8–10). ale is 1 only in clocks 1, 5 and 8. busy is 1 in clocks 1–10.
- R3: In the fetch cycle, {addrHi, adOut} equals pcIn with adOe=1 in T1. rdN is 0 in T2 only, adOe is 0 from T2 on, and ioM is 0 throughout.
- R4: The memory read cycle addresses pcIn+1, modulo 2^16, with ioM=0 and rdN=0 in T2 only. The byte on adIn at the end of T2 becomes the port number.
- R5: In the I/O cycle, ioM is 1 in all three T-states, and addrHi equals the port number throughout. In T1, adOut also equals the port number, with adOe=1.
- R6: For a read request (reqIsOut=0), rdN is 0 in T2 of the I/O cycle. The adIn byte at the end of that T2 is in acc from clock 10 onward.
- R7: For a write request (reqIsOut=1), wrN is 0 in T2 of the I/O cycle and high in T3. adOut equals acc with adOe=1 in T2 and T3. No read strobe occurs in that cycle.
- R8: rdN and wrN are never 0 in the same clock. wrN is 0 only in T2 of a write I/O cycle.
- R9: done is 1 in exactly one clock, the clock after the tenth T-state, and busy is 0 in that clock.
- R10: reqValid has no effect while busy. A request presented in the done clock is accepted, and the next run starts in the following clock.
- R11: accWrEn loads accWrData into acc at the next edge only while idle. While busy it has no effect.
- R12: adOe is 0 whenever rdN is 0, so the block never drives the data lines while it is reading them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start request, sampled while idle |
| reqIsOut | input | 1 | 1 = port write instruction, 0 = port read instruction |
| pcIn | input | 16 | Address of the opcode byte |
| accWrEn | input | 1 | Accumulator load enable (idle only) |
| accWrData | input | 8 | Accumulator load value |
| adIn | input | 8 | Data lines as seen by the block |
| adOut | output | 8 | Multiplexed low address / data out |
| adOe | output | 1 | Drive enable for adOut |
| addrHi | output | 8 | Upper address byte |
| ioM | output | 1 | High for an I/O cycle, low for memory |
| ale | output | 1 | Address latch enable, T1 of each cycle |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| busy | output | 1 | High during the 10 T-states |
| done | output | 1 | One-clock completion pulse |
| acc | output | 8 | Accumulator contents |

## Verification
Counting from the clock after the edge that samples the request:
- The fetch, port-read and I/O address phases fall in clocks 1, 5 and 8.
- The strobes fall in clocks 2, 6 and 9.
- The captured input byte is visible in acc in clock 10.
- done appears in clock 11.
- An accumulator load is visible one clock after its enable.

The bench counts the clock index, k, from the accepting edge. It drives inputs on falling edges and compares every output against the expected value for that k on the same falling edge. It supplies the opcode, the port byte and the input data on adIn only in the clocks that sample them. Disturbances (requests and accumulator loads) are injected in clock 3. They are judged by the addresses and data that appear later in the same run.

// File: rtl/portio_pkg.sv
package portio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_MEMRD = 2'd2,
    PH_IO    = 2'd3
  } seqPhase_t;

  typedef enum logic [1:0] {
    ADDR_NONE = 2'd0,
    ADDR_PC   = 2'd1,
    ADDR_PC1  = 2'd2,
    ADDR_PORT = 2'd3
  } addrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     capReq;     // latch request address
    addrSel_t addrSel;    // which address is on the bus
    logic     addrPhase;  // T1: address on low lines
    logic     dataOut;    // write cycle: accumulator on low lines
    logic     portLd;     // capture port byte from data lines
    logic     accCap;     // capture input byte into accumulator
    logic     accWrOk;    // external accumulator load permitted
  } seqStrobe_t;

endpackage

// File: rtl/portio_ctrl.sv
module portio_ctrl
  import portio_pkg::*;
#(
  parameter int FETCH_T = 4,
  parameter int MEMRD_T = 3,
  parameter int IO_T    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqIsOut,
  output seqStrobe_t strobe,
  output logic       ale,
  output logic       rdN,
  output logic       wrN,
  output logic       ioM,
  output logic       busy,
  output logic       done
);

  localparam int MAX_T = (FETCH_T > MEMRD_T) ?
                         ((FETCH_T > IO_T) ? FETCH_T : IO_T) :
                         ((MEMRD_T > IO_T) ? MEMRD_T : IO_T);
  localparam int TW = $clog2(MAX_T + 1);
  localparam logic [TW-1:0] T2_IDX = TW'(1);

  seqPhase_t     phase;
  logic [TW-1:0] tIdx;
  logic [TW-1:0] lastIdx;
  logic          isOutQ;
  logic          doneQ;
  logic          accept;
  logic          inT2;
  logic          ioWrite;

  always_comb begin
    case (phase)
      PH_FETCH: lastIdx = TW'(FETCH_T - 1);
      PH_MEMRD: lastIdx = TW'(MEMRD_T - 1);
      PH_IO:    lastIdx = TW'(IO_T - 1);
      default:  lastIdx = '0;
    endcase
  end

  assign busy    = (phase != PH_IDLE);
  assign accept  = !busy && reqValid;
  assign inT2    = busy && (tIdx == T2_IDX);
  assign ioWrite = (phase == PH_IO) && isOutQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      tIdx   <= '0;
      isOutQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (phase == PH_IDLE) begin
        if (reqValid) begin
          phase  <= PH_FETCH;
          tIdx   <= '0;
          isOutQ <= reqIsOut;
        end
      end else if (tIdx == lastIdx) begin
        tIdx <= '0;
        case (phase)
          PH_FETCH: phase <= PH_MEMRD;
          PH_MEMRD: phase <= PH_IO;
          default: begin
            phase <= PH_IDLE;
            doneQ <= 1'b1;
          end
        endcase
      end else begin
        tIdx <= tIdx + TW'(1);
      end
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.capReq    = accept;
    strobe.addrPhase = busy && (tIdx == '0);
    strobe.dataOut   = ioWrite && (tIdx != '0);
    strobe.portLd    = (phase == PH_MEMRD) && inT2;
    strobe.accCap    = (phase == PH_IO) && !isOutQ && inT2;
    strobe.accWrOk   = !busy;
    case (phase)
      PH_FETCH: strobe.addrSel = ADDR_PC;
      PH_MEMRD: strobe.addrSel = ADDR_PC1;
      PH_IO:    strobe.addrSel = ADDR_PORT;
      default:  strobe.addrSel = ADDR_NONE;
    endcase
  end

  assign ale  = busy && (tIdx == '0);
  assign ioM  = (phase == PH_IO);
  assign rdN  = !(inT2 && !ioWrite);
  assign wrN  = !(inT2 && ioWrite);
  assign done = doneQ;

endmodule

// File: rtl/portio_dp.sv
module portio_dp
  import portio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [2*DATA_W-1:0]   pcIn,
  input  logic                  accWrEn,
  input  logic [DATA_W-1:0]     accWrData,
  input  logic [DATA_W-1:0]     adIn,
  output logic [DATA_W-1:0]     adOut,
  output logic                  adOe,
  output logic [DATA_W-1:0]     addrHi,
  output logic [DATA_W-1:0]     acc
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] pcQ;
  logic [DATA_W-1:0] portQ;
  logic [DATA_W-1:0] accQ;
  logic [ADDR_W-1:0] portAddr;
  logic [ADDR_W-1:0] busAddr;

  // port number replicated into both address halves
  for (genvar g = 0; g < 2; g++) begin : gPortRep
    assign portAddr[g*DATA_W +: DATA_W] = portQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= '0;
      portQ <= '0;
      accQ  <= '0;
    end else begin
      if (strobe.capReq) pcQ <= pcIn;
      if (strobe.portLd) portQ <= adIn;
      if (strobe.accCap)
        accQ <= adIn;
      else if (strobe.accWrOk && accWrEn)
        accQ <= accWrData;
    end
  end

  always_comb begin
    case (strobe.addrSel)
      ADDR_PC:   busAddr = pcQ;
      ADDR_PC1:  busAddr = pcQ + ADDR_W'(1);
      ADDR_PORT: busAddr = portAddr;
      default:   busAddr = '0;
    endcase
  end

  always_comb begin
    adOe  = strobe.addrPhase || strobe.dataOut;
    adOut = '0;
    if (strobe.addrPhase)
      adOut = busAddr[DATA_W-1:0];
    else if (strobe.dataOut)
      adOut = accQ;
  end

  assign addrHi = busAddr[ADDR_W-1:DATA_W];
  assign acc    = accQ;

endmodule

// File: rtl/portio_seq.sv
module portio_seq
  import portio_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FETCH_T = 4,
  parameter int MEMRD_T = 3,
  parameter int IO_T    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqIsOut,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic                accWrEn,
  input  logic [DATA_W-1:0]   accWrData,
  input  logic [DATA_W-1:0]   adIn,
  output logic [DATA_W-1:0]   adOut,
  output logic                adOe,
  output logic [DATA_W-1:0]   addrHi,
  output logic                ioM,
  output logic                ale,
  output logic                rdN,
  output logic                wrN,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   acc
);

  seqStrobe_t strobe;

  portio_ctrl #(
    .FETCH_T(FETCH_T),
    .MEMRD_T(MEMRD_T),
    .IO_T   (IO_T)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqIsOut(reqIsOut),
    .strobe  (strobe),
    .ale     (ale),
    .rdN     (rdN),
    .wrN     (wrN),
    .ioM     (ioM),
    .busy    (busy),
    .done    (done)
  );

  portio_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pcIn     (pcIn),
    .accWrEn  (accWrEn),
    .accWrData(accWrData),
    .adIn     (adIn),
    .adOut    (adOut),
    .adOe     (adOe),
    .addrHi   (addrHi),
    .acc      (acc)
  );

endmodule

// File: rtl/portio_seq_chk.sv
module portio_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] adOut,
  input logic              adOe,
  input logic [DATA_W-1:0] addrHi,
  input logic              ioM,
  input logic              ale,
  input logic              rdN,
  input logic              wrN,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] acc
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (rdN && wrN && !ale && !ioM && !adOe)); // R1

  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN && adOe && busy)); // R2

  AST_IO_ADDR_DUP: assert property (@(posedge clk) disable iff (!rstN)
    (ioM && ale) |-> (addrHi == adOut)); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ioM) |=> $stable(acc)); // R11

  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe); // R12

endmodule

bind portio_seq portio_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .adOut (adOut),
  .adOe  (adOe),
  .addrHi(addrHi),
  .ioM   (ioM),
  .ale   (ale),
  .rdN   (rdN),
  .wrN   (wrN),
  .busy  (busy),
  .done  (done),
  .acc   (acc)
);

// File: tb/portio_seq_tb.sv
`timescale 1ns/1ps
module portio_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsOut = 1'b0;
  logic [15:0] pcIn = '0;
  logic        accWrEn = 1'b0;
  logic [7:0]  accWrData = '0;
  logic [7:0]  adIn = '0;
  logic [7:0]  adOut;
  logic        adOe;
  logic [7:0]  addrHi;
  logic        ioM, ale, rdN, wrN, busy, done;
  logic [7:0]  acc;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  logic [7:0] expAcc = '0;

  always #2 clk = ~clk;   // 250 MHz

  portio_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsOut(reqIsOut),
    .pcIn(pcIn), .accWrEn(accWrEn), .accWrData(accWrData), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .addrHi(addrHi), .ioM(ioM), .ale(ale),
    .rdN(rdN), .wrN(wrN), .busy(busy), .done(done), .acc(acc)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      nChecks = nChecks + 1;
      nFails  = nFails + 1;
      $display("FAIL watchdog R9: actual no completion, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // checks at the falling edge of run clock k (1..10)
  task automatic checkClock(input int k, input logic isOut, input logic [15:0] pc,
                            input logic [7:0] port);
    logic [15:0] pc1;
    pc1 = pc + 16'd1;
    chk($sformatf("R2 busy k%0d", k), busy, 1'b1);
    chk($sformatf("R2 ale k%0d", k), ale, (k == 1 || k == 5 || k == 8));
    chk($sformatf("R8 wrN k%0d", k), wrN, !(isOut && k == 9));
    chk($sformatf("R3/R4/R6 rdN k%0d", k), rdN,
        !(k == 2 || k == 6 || (!isOut && k == 9)));
    chk($sformatf("R5 ioM k%0d", k), ioM, (k >= 8));
    if (k == 1) begin
      chk("R3 fetch addr", {addrHi, adOut}, pc);
      chk("R3 fetch oe", adOe, 1'b1);
    end else if (k <= 4) begin
      chk($sformatf("R3 fetch hi k%0d", k), addrHi, pc[15:8]);
      chk($sformatf("R3 fetch oe k%0d", k), adOe, 1'b0);
    end else if (k == 5) begin
      chk("R4 memrd addr", {addrHi, adOut}, pc1);
    end else if (k <= 7) begin
      chk($sformatf("R12 memrd oe k%0d", k), adOe, 1'b0);
    end else if (k == 8) begin
      chk("R5 io addr", {addrHi, adOut}, {port, port});
      chk("R5 io oe", adOe, 1'b1);
    end else begin
      chk($sformatf("R5 io hi k%0d", k), addrHi, port);
      if (isOut) begin
        chk($sformatf("R7 data oe k%0d", k), adOe, 1'b1);
        chk($sformatf("R7 data k%0d", k), adOut, expAcc);
      end else begin
        chk($sformatf("R12 io oe k%0d", k), adOe, 1'b0);
        if (k == 10) chk("R6 acc captured", acc, expAcc);
      end
    end
  endtask

  // present request; returns at falling edge of run clock 1
  task automatic issue(input logic isOut, input logic [15:0] pc);
    reqValid = 1'b1; reqIsOut = isOut; pcIn = pc;
    @(negedge clk);
    reqValid = 1'b0; pcIn = 16'hDEAD;
  endtask

  // runs clocks 1..11, optionally disturbing in clock 3 and chaining a request in clock 11
  task automatic runBody(input logic isOut, input logic [15:0] pc, input logic [7:0] port,
                         input logic [7:0] din, input logic disturb,
                         input logic chain, input logic chainOut, input logic [15:0] chainPc);
    for (int k = 1; k <= 10; k++) begin
      adIn = (k == 6) ? port : (k == 9) ? din : (k == 2) ? 8'hDB : 8'h00;
      if (disturb && k == 3) begin
        reqValid = 1'b1; reqIsOut = !isOut; pcIn = 16'h4444;
        accWrEn = 1'b1; accWrData = ~expAcc;
      end else begin
        reqValid = 1'b0; accWrEn = 1'b0;
      end
      if (!isOut && k == 9) expAcc = din;
      checkClock(k, isOut, pc, port);
      @(negedge clk);
    end
    reqValid = 1'b0; accWrEn = 1'b0; adIn = 8'h00;
    chk("R9 done", done, 1'b1);
    chk("R9 busy low at done", busy, 1'b0);
    chk("R8 rd high at done", rdN, 1'b1);
    if (chain) begin
      issue(chainOut, chainPc);   // R10 accepted in done clock
    end else begin
      @(negedge clk);
      chk("R9 done single", done, 1'b0);
      chk("R10 no restart", busy, 1'b0);
      chk("R11 acc held", acc, expAcc);
    end
  endtask

  task automatic loadAcc(input logic [7:0] v);
    accWrEn = 1'b1; accWrData = v;
    @(negedge clk);
    accWrEn = 1'b0;
    expAcc = v;
    chk("R11 idle acc load", acc, v);
  endtask

  task automatic testReset();
    chk("R1 rdN", rdN, 1'b1);
    chk("R1 wrN", wrN, 1'b1);
    chk("R1 ale", ale, 1'b0);
    chk("R1 ioM", ioM, 1'b0);
    chk("R1 adOe", adOe, 1'b0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 addrHi", addrHi, 8'h00);
    chk("R1 acc", acc, 8'h00);
  endtask

  task automatic testPortRead();
    issue(1'b0, 16'h1234);
    runBody(1'b0, 16'h1234, 8'h5A, 8'hC3, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic testPortWrite();
    loadAcc(8'h96);
    issue(1'b1, 16'h00FF);   // R4 carry into upper byte
    runBody(1'b1, 16'h00FF, 8'hF0, 8'h77, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic testWrapAndPortZero();
    issue(1'b0, 16'hFFFF);   // R4 wraps to 0000
    runBody(1'b0, 16'hFFFF, 8'h00, 8'h3C, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic testDisturbWhileBusy();
    loadAcc(8'hA5);
    issue(1'b1, 16'h2000);   // R10 R11 disturbance in clock 3
    runBody(1'b1, 16'h2000, 8'h81, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic testBackToBack();
    issue(1'b0, 16'h8000);
    runBody(1'b0, 16'h8000, 8'hFF, 8'h5E, 1'b0, 1'b1, 1'b1, 16'h9001);
    runBody(1'b1, 16'h9001, 8'h42, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPortRead();
    testPortWrite();
    testWrapAndPortZero();
    testDisturbWhileBusy();
    testBackToBack();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule